// File: doc/BRIEF.md
# Packet Command Protocol Engine

This block is the device side of a programmed-I/O packet interface. A host reaches it through a small register window selected by a 3-bit code. Through that window it writes byte-wide task-file values and commands, moves 16-bit words through a data port, and polls a status byte. The engine handles three commands. A device reset returns the task file to its default values. A set-features command stores a transfer mode. A packet command takes a 12-byte command block as six word writes, runs it, and returns any response as word reads.

The only packet opcode served is an inquiry, which answers from a fixed 12-byte identification table. Every other opcode ends in an error status. The response is split into pieces no larger than the byte count the host loads before the packet command. A short busy phase separates each piece from the next and from the final completion, so the host sees the status byte step through ready-for-packet, busy, data-ready, busy and done. An interrupt line marks each point where the host must act.

Top module: `pkt_engine`

## Requirements
- R1: Register select codes: 0 data, 1 error (read) / feature (write), 2 count, 3 byte-count low, 4 byte-count high, 5 device select, 6 status (read) / command (write), 7 alternate status (read, writes dropped). Byte registers read back in the low byte of the 16-bit read data, with the high byte zero. After reset: status 0x50, error 0x01, count 0x01, byte count 0xEB14, transfer mode 0x00, interrupt low.
- R2: Command 0xA0 written while idle makes status and alternate status 0x58 on the next cycle, sets count to 0x01 and raises the interrupt.
- R3: The sixth data-port word of a packet makes status 0xD0. Status stays there for BUSY_CYCLES cycles (default 4) before the command is evaluated.
- R4: Opcode 0x11 (low byte of packet word 0) with allocation length L (low byte of packet word 2) returns min(L,12) bytes of the table 05 80 00 32 1F 00 00 00 50 4B 54 31. Each read word carries table byte 2k in its low half and byte 2k+1 in its high half.
- R5: Each data-ready piece holds min(remaining bytes, host byte count latched when 0xA0 is written) bytes, where a latched count of 0 means no limit. During a piece, status is 0x58, count is 0x02, the byte-count registers show the piece size and the interrupt is raised. After the last word of every piece, status is 0xD0 for BUSY_CYCLES cycles.
- R6: When the response is done, status reads 0x50, count reads 0x03 and the interrupt is raised.
- R7: Any other packet opcode ends with status 0x51, error 0x54, count 0x03 and the interrupt raised.
- R8: Command 0xEF with feature 0x03 is busy for BUSY_CYCLES cycles, copies count into the transfer-mode output, then shows status 0x50 with error 0x00. With any other feature value, or for any unknown command, it ends with status 0x51 and error 0x04.
- R9: Command 0x08 is busy for BUSY_CYCLES cycles, then restores every R1 default, including the transfer mode, and shows status 0x50.
- R10: Reading status (code 6) clears the interrupt. Reading alternate status (code 7) leaves it unchanged.
- R11: A data-port read outside a data-ready piece returns 0xFFFF and does not move the response pointer.
- R12: Register writes while status bit 7 (busy) is set are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 3 | Register select code |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; data is valid on the following cycle |
| wdata | input | 16 | Write data (byte registers use bits 7:0) |
| rdata | output | 16 | Registered read data |
| irq | output | 1 | Interrupt request to the host |
| xfer_mode | output | 8 | Transfer mode stored by set-features |

## Verification
The assertions assume the host raises at most one of rd_en and wr_en in a cycle, and that each strobe lasts one cycle per access. They also assume the host does not write the byte-count registers in the middle of a data-ready piece. The stimulus issues one single-cycle access at a time with an idle cycle between accesses. It loads the byte count only while the engine is idle and before the packet command. During busy phases it writes only registers whose effect can be seen at the ports afterwards.

// File: rtl/pkt_pkg.sv
package pkt_pkg;

  typedef enum logic [1:0] {S_IDLE, S_PKT, S_BUSY, S_DATA} state_e;

  typedef enum logic [2:0] {
    AF_RESET, AF_SETF, AF_ABORT, AF_EVAL, AF_CHUNK, AF_DONE
  } after_e;

  localparam logic [2:0] RS_DATA  = 3'd0;
  localparam logic [2:0] RS_FEAT  = 3'd1;
  localparam logic [2:0] RS_COUNT = 3'd2;
  localparam logic [2:0] RS_BCLO  = 3'd3;
  localparam logic [2:0] RS_BCHI  = 3'd4;
  localparam logic [2:0] RS_DEV   = 3'd5;
  localparam logic [2:0] RS_CMD   = 3'd6;
  localparam logic [2:0] RS_ALT   = 3'd7;

  localparam logic [7:0] STS_READY = 8'h50;
  localparam logic [7:0] STS_DRQ   = 8'h58;
  localparam logic [7:0] STS_BSY   = 8'hD0;
  localparam logic [7:0] STS_FAIL  = 8'h51;

  localparam logic [7:0] OP_PACKET  = 8'hA0;
  localparam logic [7:0] OP_DEVRST  = 8'h08;
  localparam logic [7:0] OP_SETFEAT = 8'hEF;
  localparam logic [7:0] OP_INQUIRY = 8'h11;
  localparam logic [7:0] FEAT_MODE  = 8'h03;

  localparam logic [7:0] ERR_DEFAULT = 8'h01;
  localparam logic [7:0] ERR_ABORT   = 8'h04;
  localparam logic [7:0] ERR_PKT     = 8'h54;

  localparam logic [7:0] IR_CMD  = 8'h01;
  localparam logic [7:0] IR_DATA = 8'h02;
  localparam logic [7:0] IR_DONE = 8'h03;

  localparam logic [7:0] BC_LO_DEFAULT = 8'h14;
  localparam logic [7:0] BC_HI_DEFAULT = 8'hEB;

endpackage

// File: rtl/pkt_busy_timer.sv
module pkt_busy_timer #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic expired
);
  localparam int CNT_W = (CYCLES > 1) ? $clog2(CYCLES + 1) : 1;
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  // Reload while idle, count down while the owner sits in a busy phase.
  always_ff @(posedge clk) begin
    if (rst || !active) cnt_q <= RELOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = active && (cnt_q == '0);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt_q <= RELOAD)); // R3
endmodule

// File: rtl/pkt_cmd_buf.sv
module pkt_cmd_buf #(
  parameter int WORDS = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [15:0]      wdata,
  output logic [7:0]       opcode,
  output logic [7:0]       alloc_len
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign opcode    = mem[0][7:0];
  assign alloc_len = mem[2][7:0];
endmodule

// File: rtl/pkt_id_rom.sv
module pkt_id_rom #(
  parameter int NBYTES = 12,
  parameter int PTR_W  = 4
) (
  input  logic [PTR_W-1:0] byte_addr,
  output logic [15:0]      word
);
  function automatic logic [7:0] id_byte(input int idx);
    logic [7:0] b;
    case (idx)
      0:  b = 8'h05;
      1:  b = 8'h80;
      2:  b = 8'h00;
      3:  b = 8'h32;
      4:  b = 8'h1F;
      5:  b = 8'h00;
      6:  b = 8'h00;
      7:  b = 8'h00;
      8:  b = 8'h50;
      9:  b = 8'h4B;
      10: b = 8'h54;
      11: b = 8'h31;
      default: b = 8'h00;
    endcase
    if (idx >= NBYTES) b = 8'h00;
    return b;
  endfunction

  always_comb begin
    word = {id_byte(int'(byte_addr) + 1), id_byte(int'(byte_addr))};
  end
endmodule

// File: rtl/pkt_engine.sv
module pkt_engine
  import pkt_pkg::*;
#(
  parameter int BUSY_CYCLES = 4,
  parameter int RESP_BYTES  = 12,
  parameter int PKT_WORDS   = 6
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  reg_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq,
  output logic [7:0]  xfer_mode
);
  localparam int IDX_W = (PKT_WORDS > 1) ? $clog2(PKT_WORDS) : 1;
  localparam int REM_W = $clog2(RESP_BYTES + 1);
  localparam int PTR_W = $clog2(RESP_BYTES + 2);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PKT_WORDS - 1);

  state_e            state_q;
  after_e            after_q;
  logic [7:0]        status_q, err_q, feat_q, count_q, bclo_q, bchi_q, dev_q, xfer_q;
  logic              irq_q;
  logic [15:0]       rdata_q;
  logic [IDX_W-1:0]  pkt_idx_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [REM_W-1:0]  rem_q;
  logic [15:0]       words_left_q;
  logic [15:0]       lim_q;

  logic              busy_done;
  logic              pkt_we;
  logic [7:0]        opcode, alloc_len;
  logic [15:0]       rom_word;
  logic [REM_W-1:0]  alloc_cap, rem_dec, next_rem;
  logic [15:0]       lim_eff, rem16, chunk16, words16;
  logic              wr_ok;

  assign wr_ok  = wr_en && !status_q[7];
  assign pkt_we = wr_ok && (reg_sel == RS_DATA) && (state_q == S_PKT);

  pkt_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .active(state_q == S_BUSY), .expired(busy_done)
  );

  pkt_cmd_buf #(.WORDS(PKT_WORDS), .IDX_W(IDX_W)) u_cmdbuf (
    .clk(clk), .we(pkt_we), .waddr(pkt_idx_q), .wdata(wdata),
    .opcode(opcode), .alloc_len(alloc_len)
  );

  pkt_id_rom #(.NBYTES(RESP_BYTES), .PTR_W(PTR_W)) u_rom (
    .byte_addr(ptr_q), .word(rom_word)
  );

  // Piece sizing: bytes still owed, capped by the latched host limit.
  always_comb begin
    alloc_cap = (alloc_len > 8'(RESP_BYTES)) ? REM_W'(RESP_BYTES) : REM_W'(alloc_len);
    rem_dec   = (rem_q > REM_W'(2)) ? (rem_q - REM_W'(2)) : '0;
    next_rem  = (after_q == AF_EVAL) ? alloc_cap : rem_q;
    lim_eff   = (lim_q == 16'h0000) ? 16'hFFFF : lim_q;
    rem16     = 16'(next_rem);
    chunk16   = (rem16 < lim_eff) ? rem16 : lim_eff;
    words16   = (chunk16 + 16'd1) >> 1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      after_q      <= AF_DONE;
      status_q     <= STS_READY;
      err_q        <= ERR_DEFAULT;
      feat_q       <= 8'h00;
      count_q      <= IR_CMD;
      bclo_q       <= BC_LO_DEFAULT;
      bchi_q       <= BC_HI_DEFAULT;
      dev_q        <= 8'h00;
      xfer_q       <= 8'h00;
      irq_q        <= 1'b0;
      rdata_q      <= 16'h0000;
      pkt_idx_q    <= '0;
      ptr_q        <= '0;
      rem_q        <= '0;
      words_left_q <= 16'h0000;
      lim_q        <= 16'h0000;
    end else begin
      // Host reads
      if (rd_en) begin
        case (reg_sel)
          RS_DATA:  rdata_q <= (state_q == S_DATA) ? rom_word : 16'hFFFF;
          RS_FEAT:  rdata_q <= {8'h00, err_q};
          RS_COUNT: rdata_q <= {8'h00, count_q};
          RS_BCLO:  rdata_q <= {8'h00, bclo_q};
          RS_BCHI:  rdata_q <= {8'h00, bchi_q};
          RS_DEV:   rdata_q <= {8'h00, dev_q};
          RS_CMD: begin
            rdata_q <= {8'h00, status_q};
            irq_q   <= 1'b0;
          end
          default:  rdata_q <= {8'h00, status_q};
        endcase
      end

      // Response word consumed
      if (rd_en && (reg_sel == RS_DATA) && (state_q == S_DATA)) begin
        ptr_q        <= ptr_q + PTR_W'(2);
        rem_q        <= rem_dec;
        words_left_q <= words_left_q - 16'd1;
        if (words_left_q == 16'd1) begin
          state_q  <= S_BUSY;
          status_q <= STS_BSY;
          after_q  <= (rem_dec == '0) ? AF_DONE : AF_CHUNK;
        end
      end

      // Host writes, dropped while busy
      if (wr_ok) begin
        case (reg_sel)
          RS_DATA: begin
            if (state_q == S_PKT) begin
              pkt_idx_q <= pkt_idx_q + 1'b1;
              if (pkt_idx_q == LAST_IDX) begin
                state_q  <= S_BUSY;
                status_q <= STS_BSY;
                after_q  <= AF_EVAL;
              end
            end
          end
          RS_FEAT:  feat_q  <= wdata[7:0];
          RS_COUNT: count_q <= wdata[7:0];
          RS_BCLO:  bclo_q  <= wdata[7:0];
          RS_BCHI:  bchi_q  <= wdata[7:0];
          RS_DEV:   dev_q   <= wdata[7:0];
          RS_CMD: begin
            if (state_q == S_IDLE) begin
              case (wdata[7:0])
                OP_PACKET: begin
                  state_q   <= S_PKT;
                  status_q  <= STS_DRQ;
                  count_q   <= IR_CMD;
                  err_q     <= 8'h00;
                  pkt_idx_q <= '0;
                  lim_q     <= {bchi_q, bclo_q};
                  irq_q     <= 1'b1;
                end
                OP_DEVRST: begin
                  state_q  <= S_BUSY;
                  status_q <= STS_BSY;
                  after_q  <= AF_RESET;
                end
                OP_SETFEAT: begin
                  state_q  <= S_BUSY;
                  status_q <= STS_BSY;
                  after_q  <= (feat_q == FEAT_MODE) ? AF_SETF : AF_ABORT;
                end
                default: begin
                  state_q  <= S_BUSY;
                  status_q <= STS_BSY;
                  after_q  <= AF_ABORT;
                end
              endcase
            end
          end
          default: ;
        endcase
      end

      // End of a busy phase
      if (busy_done) begin
        case (after_q)
          AF_RESET: begin
            state_q  <= S_IDLE;
            status_q <= STS_READY;
            err_q    <= ERR_DEFAULT;
            feat_q   <= 8'h00;
            count_q  <= IR_CMD;
            bclo_q   <= BC_LO_DEFAULT;
            bchi_q   <= BC_HI_DEFAULT;
            dev_q    <= 8'h00;
            xfer_q   <= 8'h00;
            irq_q    <= 1'b1;
          end
          AF_SETF: begin
            state_q  <= S_IDLE;
            status_q <= STS_READY;
            err_q    <= 8'h00;
            xfer_q   <= count_q;
            irq_q    <= 1'b1;
          end
          AF_EVAL, AF_CHUNK: begin
            if ((after_q == AF_EVAL) && (opcode != OP_INQUIRY)) begin
              state_q  <= S_IDLE;
              status_q <= STS_FAIL;
              err_q    <= ERR_PKT;
              count_q  <= IR_DONE;
              irq_q    <= 1'b1;
            end else if (next_rem == '0) begin
              state_q  <= S_IDLE;
              status_q <= STS_READY;
              count_q  <= IR_DONE;
              irq_q    <= 1'b1;
            end else begin
              if (after_q == AF_EVAL) begin
                ptr_q <= '0;
                rem_q <= alloc_cap;
              end
              state_q      <= S_DATA;
              status_q     <= STS_DRQ;
              count_q      <= IR_DATA;
              bclo_q       <= chunk16[7:0];
              bchi_q       <= chunk16[15:8];
              words_left_q <= words16;
              irq_q        <= 1'b1;
            end
          end
          AF_DONE: begin
            state_q  <= S_IDLE;
            status_q <= STS_READY;
            count_q  <= IR_DONE;
            irq_q    <= 1'b1;
          end
          default: begin
            state_q  <= S_IDLE;
            status_q <= STS_FAIL;
            err_q    <= ERR_ABORT;
            irq_q    <= 1'b1;
          end
        endcase
      end
    end
  end

  assign rdata     = rdata_q;
  assign irq       = irq_q;
  assign xfer_mode = xfer_q;

  AST_PKT_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && wr_en && reg_sel == RS_CMD && wdata[7:0] == OP_PACKET)
      |=> (status_q == STS_DRQ && irq_q)); // R2

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_BUSY && !busy_done) |=> (state_q == S_BUSY && status_q == STS_BSY)); // R3

  AST_PIECE_LIVE: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_DATA) |-> (words_left_q != 16'd0 && rem_q != '0)); // R5

  AST_IRQ_ACK: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && rd_en && !wr_en && reg_sel == RS_CMD) |=> !irq_q); // R10

  AST_DATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    (rd_en && reg_sel == RS_DATA && state_q != S_DATA)
      |=> (rdata_q == 16'hFFFF && $stable(ptr_q))); // R11

  AST_BUSY_WR_DROP: assert property (@(posedge clk) disable iff (rst)
    (status_q[7] && !busy_done && wr_en && reg_sel == RS_COUNT) |=> $stable(count_q)); // R12
endmodule

// File: tb/tb_pkt_engine.sv
`timescale 1ns/1ps
module tb_pkt_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  reg_sel = 3'd0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        irq;
  logic [7:0]  xfer_mode;

  always #2.5 clk = ~clk;

  pkt_engine dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .irq(irq), .xfer_mode(xfer_mode)
  );

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  logic rd_d = 1'b0;
  bit   finished = 1'b0;

  localparam int BUSY = 4;
  logic [7:0] tbl [12] = '{8'h05, 8'h80, 8'h00, 8'h32, 8'h1F, 8'h00,
                           8'h00, 8'h00, 8'h50, 8'h4B, 8'h54, 8'h31};

  always @(posedge clk) rd_d <= rd_en;

  // Monitor: pops the expected read value one cycle after each read strobe.
  always @(negedge clk) begin
    exp_t e;
    if (rd_d) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expectation, actual=%h expected=none", rdata);
      end else begin
        e = q.pop_front();
        if (rdata !== e.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", e.tag, rdata, e.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] sel, input logic [15:0] d);
    @(negedge clk);
    reg_sel = sel; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] sel, input logic [15:0] exp, input string tag);
    @(negedge clk);
    q.push_back('{exp, tag});
    reg_sel = sel; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] tword(input int k);
    return {tbl[2*k+1], tbl[2*k]};
  endfunction

  task automatic send_packet(input logic [7:0] op, input logic [7:0] alen);
    wr(3'd0, {8'h00, op});
    wr(3'd0, 16'h0000);
    wr(3'd0, {8'h00, alen});
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0000);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    rd(3'd7, 16'h0050, "R1 status");
    rd(3'd1, 16'h0001, "R1 error");
    rd(3'd2, 16'h0001, "R1 count");
    rd(3'd3, 16'h0014, "R1 bcount lo");
    rd(3'd4, 16'h00EB, "R1 bcount hi");
    chk({15'd0, irq}, 16'h0000, "R1 irq");
    chk({8'd0, xfer_mode}, 16'h0000, "R1 mode");

    // R11 data read while idle
    rd(3'd0, 16'hFFFF, "R11 idle data");

    // R8 set features, with a count write during busy (R12)
    wr(3'd1, 16'h0003);
    wr(3'd2, 16'h000B);
    wr(3'd6, 16'h00EF);
    rd(3'd7, 16'h00D0, "R8 busy");
    wr(3'd2, 16'h0077);
    idle(BUSY + 2);
    rd(3'd7, 16'h0050, "R8 done status");
    chk({8'd0, xfer_mode}, 16'h000B, "R12 mode unaffected by busy write");
    rd(3'd2, 16'h000B, "R12 count kept");
    rd(3'd1, 16'h0000, "R8 error clear");
    chk({15'd0, irq}, 16'h0001, "R10 irq after alt read");
    rd(3'd6, 16'h0050, "R10 status read");
    chk({15'd0, irq}, 16'h0000, "R10 irq cleared");

    // R8 bad feature
    wr(3'd1, 16'h0002);
    wr(3'd6, 16'h00EF);
    idle(BUSY + 2);
    rd(3'd6, 16'h0051, "R8 bad feature status");
    rd(3'd1, 16'h0004, "R8 bad feature error");
    chk({8'd0, xfer_mode}, 16'h000B, "R8 mode unchanged");

    // R8 unknown command
    wr(3'd6, 16'h0042);
    idle(BUSY + 2);
    rd(3'd6, 16'h0051, "R8 unknown cmd status");

    // R9 device reset
    wr(3'd2, 16'h0033);
    wr(3'd3, 16'h0099);
    wr(3'd6, 16'h0008);
    rd(3'd7, 16'h00D0, "R9 busy");
    idle(BUSY + 2);
    rd(3'd6, 16'h0050, "R9 status");
    rd(3'd2, 16'h0001, "R9 count default");
    rd(3'd3, 16'h0014, "R9 bcount default");
    rd(3'd1, 16'h0001, "R9 error default");
    chk({8'd0, xfer_mode}, 16'h0000, "R9 mode default");

    // R2..R6 inquiry in two pieces of 8 and 4 bytes
    wr(3'd3, 16'h0008);
    wr(3'd4, 16'h0000);
    wr(3'd6, 16'h00A0);
    chk({15'd0, irq}, 16'h0001, "R2 irq");
    rd(3'd7, 16'h0058, "R2 alt status");
    rd(3'd2, 16'h0001, "R2 count");
    rd(3'd6, 16'h0058, "R2 status");
    rd(3'd0, 16'hFFFF, "R11 data read in packet phase");
    send_packet(8'h11, 8'd12);
    rd(3'd7, 16'h00D0, "R3 busy after packet");
    idle(BUSY + 2);
    rd(3'd7, 16'h0058, "R5 piece1 status");
    rd(3'd2, 16'h0002, "R5 piece1 count");
    rd(3'd3, 16'h0008, "R5 piece1 size lo");
    rd(3'd4, 16'h0000, "R5 piece1 size hi");
    chk({15'd0, irq}, 16'h0001, "R5 piece1 irq");
    rd(3'd6, 16'h0058, "R5 ack");
    for (int k = 0; k < 4; k++) rd(3'd0, tword(k), "R4 word piece1");
    rd(3'd7, 16'h00D0, "R5 busy between pieces");
    rd(3'd0, 16'hFFFF, "R11 data read while busy");
    idle(BUSY + 2);
    rd(3'd7, 16'h0058, "R5 piece2 status");
    rd(3'd3, 16'h0004, "R5 piece2 size");
    rd(3'd6, 16'h0058, "R5 ack2");
    for (int k = 4; k < 6; k++) rd(3'd0, tword(k), "R4 R11 word piece2");
    rd(3'd7, 16'h00D0, "R5 busy after last piece");
    idle(BUSY + 2);
    chk({15'd0, irq}, 16'h0001, "R6 irq");
    rd(3'd6, 16'h0050, "R6 status");
    rd(3'd2, 16'h0003, "R6 count");
    rd(3'd0, 16'hFFFF, "R11 data after done");

    // R4/R5 odd length, unlimited byte count
    wr(3'd3, 16'h0000);
    wr(3'd6, 16'h00A0);
    send_packet(8'h11, 8'd5);
    idle(BUSY + 2);
    rd(3'd3, 16'h0005, "R5 single piece size");
    for (int k = 0; k < 3; k++) rd(3'd0, tword(k), "R4 odd length word");
    idle(BUSY + 2);
    rd(3'd6, 16'h0050, "R6 odd length done");

    // R7 unsupported opcode
    wr(3'd6, 16'h00A0);
    send_packet(8'h12, 8'd12);
    idle(BUSY + 2);
    rd(3'd6, 16'h0051, "R7 status");
    rd(3'd1, 16'h0054, "R7 error");
    rd(3'd2, 16'h0003, "R7 count");

    idle(3);
    if (q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual=%0d pending expected=0", q.size());
    end
    summary();
  end
endmodule